// File: doc/BRIEF.md
# Two-Level Multi-CPU Interrupt Controller

This block collects level-sensitive interrupt sources and delivers them to up to four CPUs. A source has to pass two gates before it reaches a CPU. The first is a global enable that all CPUs share. The second is a mask held separately for each CPU. Both gates are changed by writing a source index to a dedicated set or clear register, so software never has to do a read-modify-write on a shared bitmap. Sources numbered above the per-CPU range are shared. Each shared source has a control word that chooses which CPUs may receive it. Per-CPU sources (IDs 0 to 28) ignore that word.

Registers are reached through a simple single-cycle bus that has two windows. The global window holds the controller description, the enable set/clear registers and the per-source control words. The per-CPU window is banked by the CPU ID carried with the access. In that window a CPU changes its own mask bits and reads its acknowledge register. The acknowledge register returns the lowest-numbered source currently eligible for that CPU, or 1023 when none is eligible. Each CPU also has a level interrupt line that is high whenever its acknowledge value is not 1023.

Top module: `irq_dual_gate_ctrl`

## Requirements
- R1: After reset every global enable is clear, every per-CPU mask bit is set and every routing field is zero. All `cpu_irq` lines are low and every CPU's acknowledge register reads 1023.
- R2: A global-window write to offset 0x30 sets the global enable of the source whose index is in `bus_wdata[9:0]`. A write to offset 0x34 clears it.
- R3: A per-CPU-window write to offset 0x48 sets the mask bit of the indexed source for the CPU given by `bus_cpu` only. A write to offset 0x4C clears that bit. A masked source is never delivered to that CPU.
- R4: The control word of source n is at global offset 0x100 + 4*n. Bits [3:0] route the source to CPUs, with bit c standing for CPU c. Bits [11:8] are stored as a fast-interrupt routing field. All other bits read back as 0. A shared source (ID 29 and up) reaches CPU c only while its bit c in [3:0] is set.
- R5: Sources 0 through 28 are per-CPU sources. They are delivered without regard to their routing field.
- R6: A per-CPU-window read of offset 0x44 returns in bits [9:0] the lowest-numbered source that is eligible for that CPU, or 1023 if no source is eligible. The read changes no state.
- R7: Sources are level-sensitive. When a source input drops, the source stops being eligible, with no clear operation needed.
- R8: An index write (set/clear enable, set/clear mask) whose index is at or above the implemented source count changes no state. A control-word write or read for a source at or beyond that count is ignored, and the read returns 0.
- R9: A global-window read of offset 0x00 returns the implemented source count in bits [11:2] and 0 in all other bits.
- R10: `cpu_irq[c]` is high exactly when CPU c's acknowledge value differs from 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_level | input | NUM_SRC | Level of each interrupt source |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | 0 = global window, 1 = per-CPU window |
| bus_cpu | input | CPU_W | ID of the requesting CPU, used to pick the per-CPU bank |
| bus_addr | input | ADDR_W | Byte offset within the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the read |
| cpu_irq | output | NUM_CPU | Interrupt request line to each CPU |

## Verification
The bench checks that the two gates really are independent. A source that is enabled but still masked by default must stay silent, and unmasking it for one CPU must not wake any other CPU. A design that shared one mask across CPUs would assert several lines here. Routing is exercised on a shared source and left at zero on a per-CPU source. A design that applied routing to every source would lose the per-CPU delivery. A design that ignored routing would interrupt every unmasked CPU. Out-of-range indexes are chosen so that their low six bits alias a live source (73 and 521 both alias 9). A design that truncated the index instead of rejecting it would then visibly enable or drop source 9. Back-to-back acknowledge reads and a dropped lower-numbered source check that the winner is chosen by number, that the winner follows the input levels, and that nothing is consumed by a read.

// File: rtl/idg_pkg.sv
package idg_pkg;
  localparam int ID_W       = 10;
  localparam int SPURIOUS   = 1023;
  localparam int PCPU_LAST  = 28;
  localparam int DATA_W     = 32;

  localparam logic [12:0] OFS_CTRL    = 13'h000;
  localparam logic [12:0] OFS_EN_SET  = 13'h030;
  localparam logic [12:0] OFS_EN_CLR  = 13'h034;
  localparam logic [12:0] OFS_ROUTE   = 13'h100;
  localparam logic [12:0] OFS_ACK     = 13'h044;
  localparam logic [12:0] OFS_MSK_SET = 13'h048;
  localparam logic [12:0] OFS_MSK_CLR = 13'h04C;

  typedef struct packed {
    logic [3:0] fiq;
    logic [3:0] irq;
  } route_t;
endpackage

// File: rtl/idg_state.sv
module idg_state
  import idg_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NUM_CPU = 4,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              en_set,
  input  logic                              en_clr,
  input  logic                              msk_set,
  input  logic                              msk_clr,
  input  logic [CPU_W-1:0]                  wr_cpu,
  input  logic [ID_W-1:0]                   wr_idx,
  input  logic                              rt_we,
  input  logic [ID_W:0]                     rt_idx,
  input  route_t                            rt_wdata,
  output logic [NUM_SRC-1:0]                en_q,
  output logic [NUM_CPU-1:0][NUM_SRC-1:0]   msk_q,
  output route_t [NUM_SRC-1:0]              rt_q
);
  logic [NUM_SRC-1:0]              en_d;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] msk_d;
  route_t [NUM_SRC-1:0]            rt_d;
  logic                            idx_ok;
  logic                            rt_ok;
  logic                            upd;

  assign idx_ok = (32'(wr_idx) < NUM_SRC);
  assign rt_ok  = (32'(rt_idx) < NUM_SRC);
  assign upd    = en_set | en_clr | msk_set | msk_clr | rt_we;

  always_comb begin
    en_d  = en_q;
    msk_d = msk_q;
    rt_d  = rt_q;
    if (idx_ok) begin
      if (en_set)  en_d[wr_idx[SRC_W-1:0]] = 1'b1;
      if (en_clr)  en_d[wr_idx[SRC_W-1:0]] = 1'b0;
      if (msk_set) msk_d[wr_cpu][wr_idx[SRC_W-1:0]] = 1'b1;
      if (msk_clr) msk_d[wr_cpu][wr_idx[SRC_W-1:0]] = 1'b0;
    end
    if (rt_we && rt_ok) rt_d[rt_idx[SRC_W-1:0]] = rt_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      msk_q <= '1;
      rt_q  <= '0;
    end else if (upd) begin
      en_q  <= en_d;
      msk_q <= msk_d;
      rt_q  <= rt_d;
    end
  end

  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_set && idx_ok) |=> en_q[$past(wr_idx[SRC_W-1:0])]);
  // R2
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr && idx_ok) |=> !en_q[$past(wr_idx[SRC_W-1:0])]);
  // R3
  msk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_set && idx_ok) |=> msk_q[$past(wr_cpu)][$past(wr_idx[SRC_W-1:0])]);
  // R8
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_set || en_clr || msk_set || msk_clr) && !idx_ok && !rt_we)
      |=> ($stable(en_q) && $stable(msk_q)));
endmodule

// File: rtl/idg_arbiter.sv
module idg_arbiter
  import idg_pkg::*;
#(
  parameter int NUM_SRC = 40,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_level,
  input  logic [NUM_SRC-1:0] en,
  input  logic [NUM_SRC-1:0] msk,
  input  logic [NUM_SRC-1:0] reach,
  output logic               irq,
  output logic [ID_W-1:0]    ack_id
);
  logic [NUM_SRC-1:0] elig;

  assign elig = src_level & en & ~msk & reach;
  assign irq  = |elig;

  always_comb begin
    ack_id = ID_W'(SPURIOUS);
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      if (elig[s]) ack_id = ID_W'(s);
    end
  end

  // R6
  ack_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_id == ID_W'(SPURIOUS)) || (32'(ack_id) < NUM_SRC));
  // R10
  irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (ack_id != ID_W'(SPURIOUS)));
  // R6
  ack_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> elig[ack_id[SRC_W-1:0]]);
endmodule

// File: rtl/irq_dual_gate_ctrl.sv
module irq_dual_gate_ctrl
  import idg_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 13,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_level,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic               bus_win,
  input  logic [CPU_W-1:0]   bus_cpu,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [NUM_CPU-1:0] cpu_irq
);
  logic                            rst_meta_q, rst_sync_q;
  logic                            wr_g, wr_p, rd;
  logic                            en_set, en_clr, msk_set, msk_clr, rt_we;
  logic                            rt_hit;
  logic [ADDR_W-1:0]               rt_off;
  logic [ID_W:0]                   rt_idx;
  route_t                          rt_wdata;
  logic [NUM_SRC-1:0]              en_q;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] msk_q;
  route_t [NUM_SRC-1:0]            rt_q;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] reach;
  logic [NUM_CPU-1:0][ID_W-1:0]    ack;
  logic [DATA_W-1:0]               rd_d, rd_q;
  logic                            unused_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign wr_g    = bus_sel & bus_we & ~bus_win;
  assign wr_p    = bus_sel & bus_we &  bus_win;
  assign rd      = bus_sel & ~bus_we;
  assign en_set  = wr_g && (bus_addr == ADDR_W'(OFS_EN_SET));
  assign en_clr  = wr_g && (bus_addr == ADDR_W'(OFS_EN_CLR));
  assign msk_set = wr_p && (bus_addr == ADDR_W'(OFS_MSK_SET));
  assign msk_clr = wr_p && (bus_addr == ADDR_W'(OFS_MSK_CLR));

  assign rt_off   = bus_addr - ADDR_W'(OFS_ROUTE);
  assign rt_idx   = (ID_W+1)'(rt_off[ADDR_W-1:2]);
  assign rt_hit   = (bus_addr >= ADDR_W'(OFS_ROUTE)) && (bus_addr[1:0] == 2'b00);
  assign rt_we    = wr_g && rt_hit;
  assign rt_wdata = '{fiq: bus_wdata[11:8], irq: bus_wdata[3:0]};
  assign unused_ok = ^{bus_wdata[DATA_W-1:12], bus_wdata[7:4]};

  idg_state #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_state (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .en_set   (en_set),
    .en_clr   (en_clr),
    .msk_set  (msk_set),
    .msk_clr  (msk_clr),
    .wr_cpu   (bus_cpu),
    .wr_idx   (bus_wdata[ID_W-1:0]),
    .rt_we    (rt_we),
    .rt_idx   (rt_idx),
    .rt_wdata (rt_wdata),
    .en_q     (en_q),
    .msk_q    (msk_q),
    .rt_q     (rt_q)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      if (s <= PCPU_LAST) begin : g_local
        assign reach[c][s] = 1'b1;
      end else begin : g_shared
        assign reach[c][s] = rt_q[s].irq[c];
      end
    end
    idg_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
      .clk       (clk),
      .rst_n     (rst_sync_q),
      .src_level (src_level),
      .en        (en_q),
      .msk       (msk_q[c]),
      .reach     (reach[c]),
      .irq       (cpu_irq[c]),
      .ack_id    (ack[c])
    );
  end

  always_comb begin
    rd_d = '0;
    if (!bus_win) begin
      if (bus_addr == ADDR_W'(OFS_CTRL)) begin
        rd_d[11:2] = ID_W'(NUM_SRC);
      end else if (rt_hit && (32'(rt_idx) < NUM_SRC)) begin
        rd_d[11:8] = rt_q[rt_idx[SRC_W-1:0]].fiq;
        rd_d[3:0]  = rt_q[rt_idx[SRC_W-1:0]].irq;
      end
    end else if (bus_addr == ADDR_W'(OFS_ACK)) begin
      rd_d[ID_W-1:0] = ack[bus_cpu];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) rd_q <= '0;
    else if (rd)     rd_q <= rd_d;
  end

  assign bus_rdata = rd_q;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_q |-> (cpu_irq == '0));
endmodule

// File: tb/irq_dual_gate_ctrl_bench.sv
`timescale 1ns/1ps
module irq_dual_gate_ctrl_bench;
  localparam int NS = 40;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_level = '0;
  logic          bus_sel = 1'b0, bus_we = 1'b0, bus_win = 1'b0;
  logic [1:0]    bus_cpu = '0;
  logic [12:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NC-1:0] cpu_irq;
  int            errors = 0;
  int            checks = 0;

  always #5 clk = ~clk;

  irq_dual_gate_ctrl u_irq_dual_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .src_level(src_level), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_win(bus_win), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic win, input int cpu, input int addr, input int data);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_win = win;
    bus_cpu = 2'(cpu); bus_addr = 13'(addr); bus_wdata = 32'(data);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic win, input int cpu, input int addr, output int data);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_win = win;
    bus_cpu = 2'(cpu); bus_addr = 13'(addr);
    @(negedge clk);
    data = int'(bus_rdata);
    bus_sel = 1'b0;
  endtask

  task automatic ack(input int cpu, output int id);
    int v;
    rd(1'b1, cpu, 'h44, v);
    id = v & 'h3FF;
  endtask

  task automatic t_reset;
    int v;
    check("R1 irq lines", int'(cpu_irq), 0);
    for (int c = 0; c < NC; c++) begin
      ack(c, v);
      check("R1 ack idle", v, 1023);
    end
    rd(1'b0, 0, 'h00, v);
    check("R9 control word", v, NS << 2);
    rd(1'b0, 0, 'h100 + 4*33, v);
    check("R1 route zero", v, 0);
  endtask

  task automatic t_gates;
    int v;
    src_level[5] = 1'b1;
    wr(1'b0, 0, 'h30, 5);
    check("R3 default mask", int'(cpu_irq), 0);
    ack(0, v);
    check("R6 ack while masked", v, 1023);
    wr(1'b1, 0, 'h4C, 5);
    check("R3 unmask one cpu", int'(cpu_irq), 1);
    ack(0, v);
    check("R6 ack cpu0", v, 5);
    ack(1, v);
    check("R3 other cpu masked", v, 1023);
    wr(1'b0, 0, 'h34, 5);
    check("R2 enable cleared", int'(cpu_irq), 0);
    ack(0, v);
    check("R10 ack idle", v, 1023);
    wr(1'b0, 0, 'h30, 5);
    check("R2 enable set", int'(cpu_irq), 1);
    wr(1'b1, 0, 'h48, 5);
    check("R3 mask again", int'(cpu_irq), 0);
    wr(1'b0, 0, 'h34, 5);
    src_level[5] = 1'b0;
  endtask

  task automatic t_priority;
    int v;
    src_level[3] = 1'b1; src_level[7] = 1'b1;
    wr(1'b0, 0, 'h30, 7); wr(1'b0, 0, 'h30, 3);
    wr(1'b1, 0, 'h4C, 7); wr(1'b1, 0, 'h4C, 3);
    ack(0, v);
    check("R6 lowest wins", v, 3);
    ack(0, v);
    check("R6 read has no effect", v, 3);
    @(negedge clk) src_level[3] = 1'b0;
    ack(0, v);
    check("R7 level drop", v, 7);
    check("R10 irq with 7", int'(cpu_irq), 1);
    @(negedge clk) src_level[7] = 1'b0;
    @(negedge clk);
    check("R7 all dropped", int'(cpu_irq), 0);
    wr(1'b0, 0, 'h34, 3); wr(1'b0, 0, 'h34, 7);
  endtask

  task automatic t_route;
    int v;
    src_level[33] = 1'b1;
    wr(1'b0, 0, 'h30, 33);
    wr(1'b1, 1, 'h4C, 33); wr(1'b1, 2, 'h4C, 33);
    check("R4 unrouted shared", int'(cpu_irq), 0);
    wr(1'b0, 0, 'h100 + 4*33, 'hFFFF_F202);
    rd(1'b0, 0, 'h100 + 4*33, v);
    check("R4 readback", v, 'h202);
    check("R4 routed cpu1", int'(cpu_irq), 2);
    ack(1, v);
    check("R4 ack cpu1", v, 33);
    ack(2, v);
    check("R4 ack cpu2", v, 1023);
    wr(1'b0, 0, 'h100 + 4*33, 'h4);
    check("R4 reroute cpu2", int'(cpu_irq), 4);
    src_level[33] = 1'b0;
    wr(1'b0, 0, 'h34, 33);
  endtask

  task automatic t_percpu;
    int v;
    src_level[20] = 1'b1;
    wr(1'b0, 0, 'h30, 20);
    wr(1'b1, 3, 'h4C, 20);
    check("R5 per-cpu no route", int'(cpu_irq), 8);
    ack(3, v);
    check("R5 ack cpu3", v, 20);
    src_level[20] = 1'b0;
    wr(1'b0, 0, 'h34, 20);
  endtask

  task automatic t_range;
    int v;
    src_level[9] = 1'b1;
    wr(1'b1, 0, 'h4C, 9);
    wr(1'b0, 0, 'h30, 73);
    check("R8 enable idx 73 ignored", int'(cpu_irq), 0);
    wr(1'b0, 0, 'h30, 9);
    check("R2 enable 9", int'(cpu_irq), 1);
    wr(1'b1, 0, 'h48, 73);
    check("R8 mask idx 73 ignored", int'(cpu_irq), 1);
    wr(1'b0, 0, 'h34, 521);
    check("R8 clear idx 521 ignored", int'(cpu_irq), 1);
    wr(1'b0, 0, 'h100 + 4*45, 'hF);
    rd(1'b0, 0, 'h100 + 4*45, v);
    check("R8 route beyond count", v, 0);
    rd(1'b0, 0, 'h100 + 4*9, v);
    check("R8 no alias route", v, 0);
    src_level[9] = 1'b0;
    wr(1'b0, 0, 'h34, 9);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_gates();
    t_priority();
    t_route();
    t_percpu();
    t_range();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule